// File: doc/BRIEF.md
# Isochronous IN Packet Sequencer

This block takes one high-bandwidth isochronous IN transfer that belongs to a single microframe and breaks it into between one and three data packets. For each packet it decides the data PID and the byte length. A start strobe loads three values: the total byte count, the maximum packet size and the packet count. The block then presents one packet descriptor at a time. Each descriptor holds a PID level, a length and a last flag, and moves through a valid/ready handshake.

The PID level starts at the packet count minus one and counts down to DATA0, so the final packet always carries DATA0. Every packet carries the full maximum size unless fewer bytes are left. When the data runs out before the count is used up, the packets still owed go out with zero length. After the last descriptor is accepted, the block pulses done and goes back to idle.

A combination of parameters that cannot be sent sets a sticky error flag instead, and the block emits nothing. The payload fetch, the token and CRC logic, and the host-side protocol all sit outside this block.

Top module: `iso_in_seq`

## Requirements
- R1: After reset, pkt_valid_o, done_o and error_o are all 0, and no descriptor is presented until a start is accepted.
- R2: The PID code is 0 for DATA0, 1 for DATA1 and 2 for DATA2. The first descriptor carries code count−1, and each accepted descriptor lowers the code by one for the next. pkt_last_o is 1 exactly on the descriptor with code 0.
- R3: Each descriptor's length is the smaller of the maximum packet size and the bytes not yet assigned to earlier packets of the transfer (for example, 15 bytes with size 8 and count 2 gives 8 then 7).
- R4: Once the bytes are used up, the packets still owed under the count are emitted with length 0 (for example, 15 bytes with size 8 and count 3 gives 8, 7, 0).
- R5: A total of 0 with count 1 yields one zero-length DATA0 descriptor. A total of 0 with any other count is an error.
- R6: While pkt_valid_o is 1 and pkt_ready_i is 0, the PID, the length and the last flag hold their values and pkt_valid_o stays 1.
- R7: done_o is 1 for exactly the one cycle after the last descriptor is accepted, and the block then accepts a new start.
- R8: A start with a count of 0 or above 3, a maximum size of 0, or a total greater than count × size sets error_o on the next cycle. The block then presents no descriptor and gives no done pulse. error_o stays 1 until a later start is accepted.
- R9: A start strobe that arrives while a transfer is in progress is ignored, and the descriptors in flight are not changed.
- R10: The first descriptor is valid in the cycle after the start is accepted. After each accepted descriptor that is not last, the next one is valid in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| total_i | input | 12 | Total bytes for the microframe |
| mps_i | input | 11 | Maximum packet size in bytes |
| count_i | input | 3 | Packets per microframe |
| pkt_valid_o | output | 1 | Descriptor valid |
| pkt_ready_i | input | 1 | Consumer accepts the descriptor |
| pkt_pid_o | output | 2 | PID code (0 = DATA0, 1 = DATA1, 2 = DATA2) |
| pkt_len_o | output | 11 | Packet length in bytes |
| pkt_last_o | output | 1 | Final descriptor of the transfer |
| done_o | output | 1 | One-cycle pulse after the final descriptor is accepted |
| error_o | output | 1 | Sticky flag for illegal parameters |

## Verification
The assertions assume the following about the inputs:
- The consumer may hold ready low for any number of cycles.
- start_i may arrive at any time. Its operands count only in the cycle where the block is idle.
- The total, size and count ports are checked only at that moment, and their values in other cycles are free.

The stimulus drives each input half a period away from the active edge. It keeps the operands inside the port widths. It raises start only in idle, except for one deliberate mid-transfer pulse that tests R9. The ready stalls are varied so that the hold and step properties are exercised.

// File: rtl/iso_seq_pkg.sv
package iso_seq_pkg;
  localparam int TOT_W = 12;
  localparam int MPS_W = 11;
  localparam int CNT_W = 3;
  localparam int PID_W = 2;
  localparam int MAX_PKTS = 3;
  localparam int PROD_W = MPS_W + CNT_W;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_DONE} seq_state_e;

  // Largest byte count a given packet count and size can carry.
  function automatic logic [PROD_W-1:0] f_budget(input logic [CNT_W-1:0] cnt,
                                                 input logic [MPS_W-1:0] mps);
    return PROD_W'(cnt) * PROD_W'(mps);
  endfunction

  // Bytes assigned to the next packet.
  function automatic logic [MPS_W-1:0] f_pkt_len(input logic [TOT_W-1:0] rem,
                                                 input logic [MPS_W-1:0] mps);
    if (rem > TOT_W'(mps)) return mps;
    else return MPS_W'(rem);
  endfunction
endpackage

// File: rtl/iso_param_check.sv
module iso_param_check
  import iso_seq_pkg::*;
(
  input  logic [TOT_W-1:0] total_i,
  input  logic [MPS_W-1:0] mps_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             bad_o
);
  logic cnt_bad, mps_bad, over_bad, zero_bad;

  always_comb begin
    cnt_bad  = (count_i == '0) || (count_i > CNT_W'(MAX_PKTS));
    mps_bad  = (mps_i == '0);
    over_bad = PROD_W'(total_i) > f_budget(count_i, mps_i);
    zero_bad = (total_i == '0) && (count_i != CNT_W'(1));
    bad_o    = cnt_bad || mps_bad || over_bad || zero_bad;
  end
endmodule

// File: rtl/iso_pkt_slice.sv
module iso_pkt_slice
  import iso_seq_pkg::*;
(
  input  logic [TOT_W-1:0] rem_i,
  input  logic [MPS_W-1:0] mps_i,
  input  logic [PID_W-1:0] level_i,
  output logic [MPS_W-1:0] len_o,
  output logic [TOT_W-1:0] rem_next_o,
  output logic             last_o
);
  always_comb begin
    len_o      = f_pkt_len(rem_i, mps_i);
    rem_next_o = rem_i - TOT_W'(len_o);
    last_o     = (level_i == '0);
  end
endmodule

// File: rtl/iso_in_seq.sv
module iso_in_seq
  import iso_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [11:0]      total_i,
  input  logic [10:0]      mps_i,
  input  logic [2:0]       count_i,
  output logic             pkt_valid_o,
  input  logic             pkt_ready_i,
  output logic [1:0]       pkt_pid_o,
  output logic [10:0]      pkt_len_o,
  output logic             pkt_last_o,
  output logic             done_o,
  output logic             error_o
);
  seq_state_e       state_q;
  logic [TOT_W-1:0] rem_q, rem_next;
  logic [MPS_W-1:0] mps_q, len_w;
  logic [PID_W-1:0] level_q;
  logic             err_q, last_w;

  // Named events for the assertions.
  logic param_bad, start_seen, start_good, start_bad, pkt_fire, xfer_end;

  iso_param_check u_chk (
    .total_i (total_i),
    .mps_i   (mps_i),
    .count_i (count_i),
    .bad_o   (param_bad)
  );

  iso_pkt_slice u_slice (
    .rem_i      (rem_q),
    .mps_i      (mps_q),
    .level_i    (level_q),
    .len_o      (len_w),
    .rem_next_o (rem_next),
    .last_o     (last_w)
  );

  assign start_seen = start_i && (state_q == ST_IDLE);
  assign start_good = start_seen && !param_bad;
  assign start_bad  = start_seen && param_bad;
  assign pkt_fire   = (state_q == ST_SEND) && pkt_ready_i;
  assign xfer_end   = pkt_fire && last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      mps_q   <= '0;
      level_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_good) begin
            rem_q   <= total_i;
            mps_q   <= mps_i;
            level_q <= PID_W'(count_i - CNT_W'(1));
            err_q   <= 1'b0;
            state_q <= ST_SEND;
          end else if (start_bad) begin
            err_q   <= 1'b1;
          end
        end
        ST_SEND: begin
          if (pkt_fire) begin
            rem_q <= rem_next;
            if (last_w) state_q <= ST_DONE;
            else        level_q <= level_q - PID_W'(1);
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pkt_valid_o = (state_q == ST_SEND);
  assign pkt_pid_o   = level_q;
  assign pkt_len_o   = len_w;
  assign pkt_last_o  = pkt_valid_o && last_w;
  assign done_o      = (state_q == ST_DONE);
  assign error_o     = err_q;

  // R6: a stalled descriptor is held
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_pid_o)
      && $stable(pkt_len_o) && $stable(pkt_last_o));

  // R2 and R10: after a non-final handshake the next descriptor is one level lower
  p_pid_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_fire && !pkt_last_o |=> pkt_valid_o && (pkt_pid_o == $past(pkt_pid_o) - 2'd1));

  // R2: the final descriptor is DATA0
  p_last_data0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o && pkt_last_o |-> pkt_pid_o == 2'd0);

  // R3: no packet is longer than the latched size
  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid_o |-> pkt_len_o <= mps_q);

  // R7: done follows the final handshake and lasts one cycle
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> done_o && !pkt_valid_o);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: a rejected start raises error and presents nothing
  p_err_no_pkt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> error_o && !pkt_valid_o && !done_o);

  // R10: an accepted start presents the first descriptor next cycle
  p_first_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_good |=> pkt_valid_o && !error_o);
endmodule

// File: tb/sim_iso_in_seq.sv
`timescale 1ns/1ps
module sim_iso_in_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] total_i = '0;
  logic [10:0] mps_i = '0;
  logic [2:0]  count_i = '0;
  logic        pkt_ready_i = 1'b0;
  logic        pkt_valid_o, pkt_last_o, done_o, error_o;
  logic [1:0]  pkt_pid_o;
  logic [10:0] pkt_len_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  iso_in_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_i(total_i),
    .mps_i(mps_i), .count_i(count_i), .pkt_valid_o(pkt_valid_o),
    .pkt_ready_i(pkt_ready_i), .pkt_pid_o(pkt_pid_o), .pkt_len_o(pkt_len_o),
    .pkt_last_o(pkt_last_o), .done_o(done_o), .error_o(error_o)
  );

  // {total, size, count, expect_error}
  localparam int NV = 14;
  localparam logic [26:0] VEC [NV] = '{
    {12'd15,   11'd8,    3'd3, 1'b0},
    {12'd15,   11'd8,    3'd2, 1'b0},
    {12'd0,    11'd8,    3'd1, 1'b0},
    {12'd0,    11'd8,    3'd2, 1'b1},
    {12'd3072, 11'd1024, 3'd3, 1'b0},
    {12'd1024, 11'd1024, 3'd1, 1'b0},
    {12'd1000, 11'd512,  3'd3, 1'b0},
    {12'd9,    11'd8,    3'd0, 1'b1},
    {12'd9,    11'd8,    3'd4, 1'b1},
    {12'd9,    11'd0,    3'd2, 1'b1},
    {12'd17,   11'd8,    3'd2, 1'b1},
    {12'd2048, 11'd1024, 3'd3, 1'b0},
    {12'd1,    11'd1,    3'd1, 1'b0},
    {12'd5,    11'd2,    3'd3, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input int tot, input int mps, input int cnt);
    total_i = 12'(tot); mps_i = 11'(mps); count_i = 3'(cnt); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Called at the negedge after the start edge; walks the whole transfer.
  task automatic collect(input int tot, input int mps, input int cnt, input bit stall);
    int rem = tot;
    for (int lvl = cnt - 1; lvl >= 0; lvl--) begin
      int elen = (rem > mps) ? mps : rem;
      check("R10 valid", int'(pkt_valid_o), 1);
      check("R2 pid", int'(pkt_pid_o), lvl);
      check("R2 last", int'(pkt_last_o), (lvl == 0) ? 1 : 0);
      check((rem == 0) ? "R4 zero len" : "R3 len", int'(pkt_len_o), elen);
      if (tot == 0) check("R5 zero total", int'(pkt_len_o), 0);
      if (stall) begin
        pkt_ready_i = 1'b0;
        @(negedge clk);
        check("R6 hold valid", int'(pkt_valid_o), 1);
        check("R6 hold pid", int'(pkt_pid_o), lvl);
        check("R6 hold len", int'(pkt_len_o), elen);
      end
      pkt_ready_i = 1'b1;
      @(negedge clk);
      pkt_ready_i = 1'b0;
      rem = rem - elen;
    end
    check("R7 done", int'(done_o), 1);
    check("R7 valid low", int'(pkt_valid_o), 0);
    @(negedge clk);
    check("R7 done pulse", int'(done_o), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", int'(pkt_valid_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 error", int'(error_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", int'(pkt_valid_o), 0);

    for (int i = 0; i < NV; i++) begin
      int tot = int'(VEC[i][26:15]);
      int mps = int'(VEC[i][14:4]);
      int cnt = int'(VEC[i][3:1]);
      bit err = VEC[i][0];
      do_start(tot, mps, cnt);
      if (err) begin
        check("R8 error set", int'(error_o), 1);
        check("R8 no pkt", int'(pkt_valid_o), 0);
        @(negedge clk);
        check("R8 still no pkt", int'(pkt_valid_o), 0);
        check("R8 no done", int'(done_o), 0);
        check("R8 sticky", int'(error_o), 1);
      end else begin
        check("R8 error clear", int'(error_o), 0);
        collect(tot, mps, cnt, i[0]);
      end
    end

    // R9: a start during a transfer changes nothing
    do_start(3072, 1024, 3);
    do_start(5, 2, 1);
    check("R9 pid kept", int'(pkt_pid_o), 2);
    check("R9 len kept", int'(pkt_len_o), 1024);
    check("R9 valid kept", int'(pkt_valid_o), 1);
    collect(3072, 1024, 3, 1'b0);

    // R7: back-to-back transfer straight after done
    do_start(7, 4, 2);
    collect(7, 4, 2, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule